// File: doc/BRIEF.md
# Sv39 Page Table Walker

This block translates a 64-bit virtual address into a physical address. It walks a three-level Sv39 page table held in a memory of 64-bit words, one translation at a time. A request carries the virtual address, the current privilege mode and the address-translation control register. When translation is switched off, the block returns the address unchanged and reads nothing. When translation is on, it fetches one table entry per level through a read port with a valid/ready handshake. The memory may take any number of wait cycles per fetch.

The walk stops at the first entry that is a leaf. The block then builds a 1 GiB, 2 MiB or 4 KiB physical address from that leaf and the untranslated virtual-address fields. It ends with a single-cycle `done` pulse, or with a single-cycle `fault` pulse when an entry is invalid or the last level holds no leaf. It is meant to sit behind a translation cache that calls it on a miss.

Top module: `pageTableWalker`

## Requirements
- R1: When `reqSatp[63]` is 0 or `reqPriv` is 2'b11 (machine mode), an accepted request raises `done` in the cycle after acceptance, with `paddr` equal to `reqVaddr` and no memory read.
- R2: When translation is on, the first read is issued in the cycle after acceptance. Its word index is `{reqSatp[43:0], reqVaddr[38:30]}`, which is the root base (satp bits 43:0 shifted left by 12) plus the level-2 index times 8, divided by 8.
- R3: A valid non-leaf entry at level L (L > 0) makes the next read use word index `{pte[53:10], vpn(L-1)}`. Here vpn1 is vaddr[29:21] and vpn0 is vaddr[20:12].
- R4: An entry is a leaf when its valid bit (bit 0) is 1 and either bit 1 (read) or bit 3 (execute) is 1. Read-only leaves and execute-only leaves both end the walk.
- R5: A leaf at level 2 gives `paddr = {8'b0, pte[53:28], vaddr[29:21], vaddr[20:12], vaddr[11:0]}`.
- R6: A leaf at level 1 gives `paddr = {8'b0, pte[53:19], vaddr[20:12], vaddr[11:0]}`.
- R7: A leaf at level 0 gives `paddr = {8'b0, pte[53:10], vaddr[11:0]}`, after exactly three reads.
- R8: A fetched entry with bit 0 clear ends the walk with `fault`, whatever its other bits are, and no further read is made.
- R9: A valid non-leaf entry at level 0 ends the walk with `fault` after three reads.
- R10: While `memReqValid` is high and `memReady` is low, `memReqValid` stays high and `memAddr` stays stable. Any number of wait cycles gives the same result.
- R11: `reqReady` is high only when idle. A request presented while a walk is in progress is ignored and does not disturb that walk.
- R12: `done` and `fault` are never high together. Each is a one-cycle pulse, raised in the cycle after the handshake that returned the final entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Block idle, request will be taken |
| reqVaddr | input | 64 | Virtual address to translate |
| reqPriv | input | 2 | Current privilege mode, 2'b11 = machine |
| reqSatp | input | 64 | Translation control register: bit 63 enable, bits 43:0 root page number |
| memReqValid | output | 1 | Table-entry read request |
| memReady | input | 1 | Read accepted, `memData` valid this cycle |
| memAddr | output | 53 | Word index of the entry to read |
| memData | input | 64 | Entry returned by memory |
| done | output | 1 | One-cycle pulse: `paddr` holds the result |
| fault | output | 1 | One-cycle pulse: the walk failed |
| paddr | output | 64 | Physical address of the last successful translation |

## Verification
A bypassed request produces `done` one cycle after the accepting edge. A translating request presents its root read one cycle after acceptance. A walk's `done` or `fault` follows one cycle after the handshake edge of its final entry. The bench's memory model raises `memReady` on falling edges after a configurable number of wait cycles. It records the cycle of each handshake and the index read, and it checks that the pending index does not change while it waits. Results are sampled on falling edges and compared against the recorded handshake cycle plus one. The read count and the logged indices confirm that the walk stops at the right level.

// File: rtl/ptwPkg.sv
package ptwPkg;
  localparam int VA_W      = 64;
  localparam int PA_W      = 64;
  localparam int PTE_W     = 64;
  localparam int VPN_W     = 9;
  localparam int OFF_W     = 12;
  localparam int PPN_W     = 44;
  localparam int LEVELS    = 3;
  localparam int PPN_LSB   = 10;
  localparam int LVL_W     = $clog2(LEVELS);
  localparam int WIDX_W    = PPN_W + VPN_W;
  localparam int EN_BIT    = 63;
  localparam logic [1:0] MACHINE_PRIV = 2'b11;

  typedef enum logic [0:0] {
    WALK_IDLE  = 1'b0,
    WALK_FETCH = 1'b1
  } walkState_t;

  typedef struct packed {
    logic capture;
    logic descend;
    logic takeLeaf;
    logic takeBypass;
  } ptwCtl_t;
endpackage

// File: rtl/ptwDatapath.sv
module ptwDatapath
  import ptwPkg::*;
#(
  parameter int P_VA_W   = VA_W,
  parameter int P_PTE_W  = PTE_W,
  parameter int P_VPN_W  = VPN_W,
  parameter int P_OFF_W  = OFF_W,
  parameter int P_PPN_W  = PPN_W,
  parameter int P_LEVELS = LEVELS,
  parameter int P_LVL_W  = LVL_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ptwCtl_t                      ctl,
  input  logic [P_VA_W-1:0]            reqVaddr,
  input  logic [P_PPN_W-1:0]           rootPpn,
  input  logic [P_PTE_W-1:0]           memData,
  output logic [P_PPN_W+P_VPN_W-1:0]   memAddr,
  output logic                         pteValid,
  output logic                         pteLeaf,
  output logic                         atBottom,
  output logic [P_VA_W-1:0]            paddr
);
  localparam int SLOTS   = 2 ** P_LVL_W;
  localparam int VPN_ALL = P_LEVELS * P_VPN_W;

  logic [P_VA_W-1:0]  vaddrQ;
  logic [P_PPN_W-1:0] baseQ;
  logic [P_LVL_W-1:0] levelQ;
  logic [P_VA_W-1:0]  paddrQ;

  logic [P_PPN_W-1:0] ptePpn;
  logic [P_PPN_W-1:0] vaVpnBits;
  logic [P_VPN_W-1:0] vpnArr  [SLOTS];
  logic [P_VA_W-1:0]  leafArr [SLOTS];

  assign ptePpn    = memData[PPN_LSB +: P_PPN_W];
  assign vaVpnBits = P_PPN_W'(vaddrQ[P_OFF_W +: VPN_ALL]);

  // Per-level index slice and leaf composition: a leaf found at level g
  // keeps the low g*VPN_W page-number bits from the virtual address.
  for (genvar g = 0; g < SLOTS; g++) begin : gLevel
    if (g < P_LEVELS) begin : gReal
      localparam logic [P_PPN_W-1:0] LOW_MASK =
        (P_PPN_W'(1) << (g * P_VPN_W)) - P_PPN_W'(1);
      logic [P_PPN_W-1:0] mixedPpn;
      assign mixedPpn   = (ptePpn & ~LOW_MASK) | (vaVpnBits & LOW_MASK);
      assign vpnArr[g]  = vaddrQ[P_OFF_W + g*P_VPN_W +: P_VPN_W];
      assign leafArr[g] = P_VA_W'({mixedPpn, vaddrQ[P_OFF_W-1:0]});
    end else begin : gPad
      assign vpnArr[g]  = '0;
      assign leafArr[g] = '0;
    end
  end

  assign memAddr  = {baseQ, vpnArr[levelQ]};
  assign pteValid = memData[0];
  assign pteLeaf  = memData[1] | memData[3];
  assign atBottom = (levelQ == '0);
  assign paddr    = paddrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaddrQ <= '0;
      baseQ  <= '0;
      levelQ <= '0;
    end else if (ctl.capture) begin
      vaddrQ <= reqVaddr;
      baseQ  <= rootPpn;
      levelQ <= P_LVL_W'(P_LEVELS - 1);
    end else if (ctl.descend) begin
      baseQ  <= ptePpn;
      levelQ <= levelQ - P_LVL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      paddrQ <= '0;
    end else if (ctl.takeBypass) begin
      paddrQ <= reqVaddr;
    end else if (ctl.takeLeaf) begin
      paddrQ <= leafArr[levelQ];
    end
  end
endmodule

// File: rtl/ptwControl.sv
module ptwControl
  import ptwPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqPriv,
  input  logic       satpOn,
  input  logic       memReady,
  input  logic       pteValid,
  input  logic       pteLeaf,
  input  logic       atBottom,
  output ptwCtl_t    ctl,
  output logic       reqReady,
  output logic       memReqValid,
  output logic       done,
  output logic       fault
);
  walkState_t stateQ, stateD;
  logic doneQ, faultQ;
  logic accept, translateOn, resp, badEntry;

  assign reqReady    = (stateQ == WALK_IDLE);
  assign memReqValid = (stateQ == WALK_FETCH);
  assign accept      = reqValid && reqReady;
  assign translateOn = satpOn && (reqPriv != MACHINE_PRIV);
  assign resp        = memReqValid && memReady;
  assign badEntry    = resp && (!pteValid || (!pteLeaf && atBottom));

  always_comb begin
    ctl            = '0;
    ctl.capture    = accept && translateOn;
    ctl.takeBypass = accept && !translateOn;
    ctl.takeLeaf   = resp && pteValid && pteLeaf;
    ctl.descend    = resp && pteValid && !pteLeaf && !atBottom;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      WALK_IDLE:  if (ctl.capture) stateD = WALK_FETCH;
      WALK_FETCH: if (ctl.takeLeaf || badEntry) stateD = WALK_IDLE;
      default:    stateD = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= WALK_IDLE;
      doneQ  <= 1'b0;
      faultQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= ctl.takeLeaf || ctl.takeBypass;
      faultQ <= badEntry;
    end
  end

  assign done  = doneQ;
  assign fault = faultQ;
endmodule

// File: rtl/pageTableWalker.sv
module pageTableWalker
  import ptwPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [1:0]        reqPriv,
  input  logic [63:0]       reqSatp,
  output logic              memReqValid,
  input  logic              memReady,
  output logic [WIDX_W-1:0] memAddr,
  input  logic [PTE_W-1:0]  memData,
  output logic              done,
  output logic              fault,
  output logic [PA_W-1:0]   paddr
);
  ptwCtl_t ctl;
  logic pteValid, pteLeaf, atBottom;

  ptwControl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqPriv(reqPriv), .satpOn(reqSatp[EN_BIT]),
    .memReady(memReady),
    .pteValid(pteValid), .pteLeaf(pteLeaf), .atBottom(atBottom),
    .ctl(ctl), .reqReady(reqReady), .memReqValid(memReqValid),
    .done(done), .fault(fault)
  );

  ptwDatapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqVaddr(reqVaddr), .rootPpn(reqSatp[PPN_W-1:0]),
    .memData(memData), .memAddr(memAddr),
    .pteValid(pteValid), .pteLeaf(pteLeaf), .atBottom(atBottom),
    .paddr(paddr)
  );
endmodule

// File: rtl/ptwChecker.sv
module ptwChecker
  import ptwPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [VA_W-1:0]   reqVaddr,
  input logic [1:0]        reqPriv,
  input logic [63:0]       reqSatp,
  input logic              memReqValid,
  input logic              memReady,
  input logic [WIDX_W-1:0] memAddr,
  input logic              done,
  input logic              fault,
  input logic [PA_W-1:0]   paddr
);
  logic takeOff, takeOn;
  assign takeOff = reqValid && reqReady && (!reqSatp[EN_BIT] || reqPriv == MACHINE_PRIV);
  assign takeOn  = reqValid && reqReady && reqSatp[EN_BIT] && reqPriv != MACHINE_PRIV;

  // R1
  bypass_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeOff |=> done && !memReqValid && paddr == $past(reqVaddr));

  // R2
  root_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeOn |=> memReqValid && memAddr == {$past(reqSatp[PPN_W-1:0]), $past(reqVaddr[38:30])});

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReady |=> memReqValid && $stable(memAddr));

  // R11
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

  // R12
  excl_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, fault}));

  // R12
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> !fault);

  // R12
  result_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done || fault) |-> $past(memReqValid && memReady) || $past(reqValid && reqReady));
endmodule

bind pageTableWalker ptwChecker chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqVaddr(reqVaddr), .reqPriv(reqPriv), .reqSatp(reqSatp),
  .memReqValid(memReqValid), .memReady(memReady), .memAddr(memAddr),
  .done(done), .fault(fault), .paddr(paddr)
);

// File: tb/pageTableWalker_tb_top.sv
module pageTableWalker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [63:0] reqVaddr = '0;
  logic [1:0]  reqPriv = 2'b01;
  logic [63:0] reqSatp = '0;
  logic        memReqValid;
  logic        memReady = 1'b0;
  logic [52:0] memAddr;
  logic [63:0] memData = '0;
  logic        done, fault;
  logic [63:0] paddr;

  pageTableWalker dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqPriv(reqPriv), .reqSatp(reqSatp),
    .memReqValid(memReqValid), .memReady(memReady), .memAddr(memAddr),
    .memData(memData), .done(done), .fault(fault), .paddr(paddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFail = 0;

  task automatic chkEq(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [52:0] mAddr [8];
  logic [63:0] mData [8];
  int          mCount = 0;
  int          waitCfg = 0;
  int          readCount = 0;
  logic [52:0] readLog [4];
  int          lastHsCyc = 0;
  int          holdErr = 0;
  int          waited = 0;
  logic        prevValid = 1'b0;
  logic [52:0] prevAddr = '0;

  function automatic logic [63:0] lookup(logic [52:0] a);
    for (int i = 0; i < mCount; i++) if (mAddr[i] == a) return mData[i];
    return 64'h0;
  endfunction

  task automatic memClear(int w);
    mCount = 0; readCount = 0; holdErr = 0; waitCfg = w;
    for (int i = 0; i < 4; i++) readLog[i] = '0;
  endtask

  task automatic memPut(logic [43:0] base, logic [8:0] idx, logic [63:0] d);
    mAddr[mCount] = {base, idx};
    mData[mCount] = d;
    mCount++;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (memReady) begin
        memReady = 1'b0; waited = 0; prevValid = 1'b0;
      end
      if (memReqValid) begin
        if (prevValid && memAddr != prevAddr) holdErr++;
        prevAddr = memAddr; prevValid = 1'b1;
        if (waited >= waitCfg) begin
          memReady = 1'b1;
          memData = lookup(memAddr);
          if (readCount < 4) readLog[readCount] = memAddr;
          readCount++;
          lastHsCyc = cyc;
        end else begin
          waited++;
        end
      end else begin
        prevValid = 1'b0;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  localparam logic [43:0] ROOT = 44'h080;
  localparam logic [43:0] L1B  = 44'h081;
  localparam logic [43:0] L0B  = 44'h082;
  localparam logic [43:0] LEAF = 44'h123_4567_89AB;
  localparam logic [8:0]  V2 = 9'h001, V1 = 9'h0A2, V0 = 9'h145;
  localparam logic [11:0] OFS = 12'h678;
  localparam logic [63:0] VA  = {25'h0, V2, V1, V0, OFS};
  localparam logic [63:0] SATP_ON  = {1'b1, 19'h0, ROOT};
  localparam logic [63:0] SATP_OFF = {1'b0, 19'h0, ROOT};

  function automatic logic [63:0] mkPte(logic [43:0] ppn, logic [9:0] flags);
    return {10'h0, ppn, flags};
  endfunction

  logic        gotDone, gotFault;
  logic [63:0] gotPa;
  int          resCyc;

  task automatic runWalk(logic [63:0] va, logic [1:0] priv, logic [63:0] satp);
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqPriv = priv; reqSatp = satp;
    gotDone = 1'b0; gotFault = 1'b0; gotPa = '0; resCyc = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
      if (done || fault) begin
        gotDone = done; gotFault = fault; gotPa = paddr; resCyc = cyc;
        break;
      end
    end
    @(negedge clk);
  endtask

  task automatic buildKiloChain(logic [9:0] leafFlags);
    memPut(ROOT, V2, mkPte(L1B, 10'h001));
    memPut(L1B, V1, mkPte(L0B, 10'h001));
    memPut(L0B, V0, mkPte(LEAF, leafFlags));
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    chkEq("R12 reset done", {63'h0, done}, 64'h0);
    chkEq("R12 reset fault", {63'h0, fault}, 64'h0);
    chkEq("R11 reset ready", {63'h0, reqReady}, 64'h1);
    chkEq("R10 reset memReqValid", {63'h0, memReqValid}, 64'h0);
  endtask

  task automatic testBypass();
    memClear(0);
    runWalk(VA, 2'b01, SATP_OFF);
    chkEq("R1 disabled done", {63'h0, gotDone}, 64'h1);
    chkEq("R1 disabled paddr", gotPa, VA);
    chkEq("R1 disabled no reads", 64'(readCount), 64'h0);
    memClear(0);
    runWalk(64'hFFFF_FFC0_DEAD_BEEF, 2'b11, SATP_ON);
    chkEq("R1 machine done", {63'h0, gotDone}, 64'h1);
    chkEq("R1 machine paddr", gotPa, 64'hFFFF_FFC0_DEAD_BEEF);
    chkEq("R1 machine no reads", 64'(readCount), 64'h0);
  endtask

  task automatic testGiga();
    memClear(0);
    memPut(ROOT, V2, mkPte(LEAF, 10'h003));
    runWalk(VA, 2'b01, SATP_ON);
    chkEq("R2 root index", {11'h0, readLog[0]}, {11'h0, ROOT, V2});
    chkEq("R5 giga done", {63'h0, gotDone}, 64'h1);
    chkEq("R5 giga paddr", gotPa, {8'h0, LEAF[43:18], V1, V0, OFS});
    chkEq("R4 read-only leaf stops", 64'(readCount), 64'h1);
    chkEq("R12 giga timing", 64'(resCyc), 64'(lastHsCyc + 1));
  endtask

  task automatic testMega();
    memClear(0);
    memPut(ROOT, V2, mkPte(L1B, 10'h001));
    memPut(L1B, V1, mkPte(LEAF, 10'h009));
    runWalk(VA, 2'b00, SATP_ON);
    chkEq("R3 level1 index", {11'h0, readLog[1]}, {11'h0, L1B, V1});
    chkEq("R6 mega paddr", gotPa, {8'h0, LEAF[43:9], V0, OFS});
    chkEq("R4 exec-only leaf stops", 64'(readCount), 64'h2);
    chkEq("R6 mega done", {63'h0, gotDone}, 64'h1);
  endtask

  task automatic testKilo(int w);
    memClear(w);
    buildKiloChain(10'h0C7);
    runWalk(VA, 2'b01, SATP_ON);
    chkEq("R3 level0 index", {11'h0, readLog[2]}, {11'h0, L0B, V0});
    chkEq("R7 kilo paddr", gotPa, {8'h0, LEAF, OFS});
    chkEq("R7 kilo reads", 64'(readCount), 64'h3);
    chkEq("R12 kilo timing", 64'(resCyc), 64'(lastHsCyc + 1));
    chkEq("R10 address held while waiting", 64'(holdErr), 64'h0);
  endtask

  task automatic testFaultInvalid();
    memClear(0);
    memPut(ROOT, V2, mkPte(L1B, 10'h001));
    runWalk(VA, 2'b01, SATP_ON);
    chkEq("R8 missing entry fault", {62'h0, gotFault, gotDone}, 64'h2);
    chkEq("R8 stop after invalid", 64'(readCount), 64'h2);
    memClear(2);
    memPut(ROOT, V2, mkPte(LEAF, 10'h00A));
    runWalk(VA, 2'b01, SATP_ON);
    chkEq("R8 invalid leaf-like fault", {62'h0, gotFault, gotDone}, 64'h2);
    chkEq("R8 single read", 64'(readCount), 64'h1);
    chkEq("R12 fault timing", 64'(resCyc), 64'(lastHsCyc + 1));
  endtask

  task automatic testFaultBottom();
    memClear(1);
    buildKiloChain(10'h001);
    runWalk(VA, 2'b01, SATP_ON);
    chkEq("R9 level0 pointer fault", {62'h0, gotFault, gotDone}, 64'h2);
    chkEq("R9 three reads", 64'(readCount), 64'h3);
  endtask

  task automatic testBusyIgnore();
    int extra;
    memClear(6);
    buildKiloChain(10'h0C3);
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = VA; reqPriv = 2'b01; reqSatp = SATP_ON;
    @(negedge clk);
    reqVaddr = 64'h0000_0000_5555_0000; reqSatp = SATP_OFF;
    for (int i = 0; i < 3; i++) begin
      chkEq("R11 not ready while walking", {63'h0, reqReady}, 64'h0);
      chkEq("R11 ignored request gives no done", {63'h0, done}, 64'h0);
      @(negedge clk);
    end
    reqValid = 1'b0;
    gotDone = 1'b0; gotPa = '0;
    for (int i = 0; i < 400; i++) begin
      if (done || fault) begin gotDone = done; gotPa = paddr; break; end
      @(negedge clk);
    end
    chkEq("R11 walk result undisturbed", gotPa, {8'h0, LEAF, OFS});
    extra = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (done || fault) extra++;
    end
    chkEq("R11 ignored request never served", 64'(extra), 64'h0);
  endtask

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBypass();
    testGiga();
    testMega();
    testKilo(0);
    testKilo(4);
    testFaultInvalid();
    testFaultBottom();
    testBusyIgnore();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++; nFail++;
    $display("FAIL R12 watchdog actual=hang expected=completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule